// File: doc/BRIEF.md
# Bus Ownership Controller for Hold and Backoff

This block decides who owns a processor's local bus. Another master can ask for the bus in two ways. The first is a polite hold request, which waits for the current bus cycle to end. The block answers it with an acknowledge and floats the address, data and control pins. The second is an active-low backoff input. Backoff takes effect at any clock and gives no acknowledge. It overrides a ready returned in the same clock and cancels the interrupted cycle, which must then be repeated.

The block sits next to the bus-cycle sequencer. The sequencer reports whether a cycle is in flight and whether the current transfer is its last. The block tells the sequencer three things: when a transfer is accepted, when an in-flight cycle is aborted, and when to restart that cycle from its first transfer. The single float output drives the output enables of the pad ring. The reset input is asynchronous active-low and its release is synchronised inside the block.

Top module: `bus_own_ctrl`

## Requirements
- R1: While reset is active, and for the clocks of synchronised release afterwards, hold_ack, bus_float and cyc_restart are 0, whatever the other inputs do.
- R2: With no cycle in flight (cyc_busy = 0), a hold_req sampled high at a clock edge makes hold_ack and bus_float both go to 1 after that same edge, in the same clock.
- R3: A hold_req that arrives during a cycle is granted only at a cycle boundary. A boundary is a clock with cyc_busy = 0, or an accepted transfer with cyc_last = 1. hold_ack rises after the edge that closes the cycle.
- R4: With backoff inactive, hold_ack and bus_float return to 0 after the first edge at which hold_req is sampled low.
- R5: backoff_n sampled low at an edge makes bus_float 1 after that edge, and never causes hold_ack to rise.
- R6: When backoff_n is low, xfer_done is 0 even if rdy_n or brdy_n is low. If cyc_busy is 1 in the first such clock, cyc_abort is 1 in that clock.
- R7: bus_float stays 1 for every clock that follows an edge at which backoff_n was sampled low.
- R8: If a cycle was aborted by backoff, cyc_restart is 1 for exactly one clock: the clock after the edge at which backoff_n is first sampled high again. If no cycle was aborted, no pulse is given.
- R9: If hold and backoff overlap, bus_float stays 1 until both are released. hold_ack follows only the hold handshake, and a hold may be granted during backoff when no cycle is in flight.
- R10: xfer_done is 1 when cyc_busy is 1, rdy_n or brdy_n (or both) is low, backoff_n is high and the bus is not floated. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req | input | 1 | Request from another master to take the bus at a cycle boundary |
| backoff_n | input | 1 | Active-low immediate backoff request |
| rdy_n | input | 1 | Active-low non-burst ready |
| brdy_n | input | 1 | Active-low burst ready |
| cyc_busy | input | 1 | Sequencer has a bus cycle in flight |
| cyc_last | input | 1 | Current transfer is the last of the cycle |
| hold_ack | output | 1 | Hold granted; bus released to the other master |
| bus_float | output | 1 | Float the address, data and control pins |
| xfer_done | output | 1 | Current transfer accepted by the sequencer |
| cyc_abort | output | 1 | In-flight cycle cancelled by backoff in this clock |
| cyc_restart | output | 1 | One-clock pulse: repeat the aborted cycle from its start |

## Verification
The stimulus runs hold requests in three situations: on an idle bus, in the middle of a multi-transfer cycle, and at the last transfer of a cycle. Together these separate grant timing at a boundary from a grant that comes too early. Backoff is applied on a busy bus with a ready in the same clock, on an idle bus, over a hold already granted, and under a hold that arrives during backoff. These cases show whether backoff wins the conflict with ready, whether a restart pulse follows only a real abort, and whether the acknowledge stays tied to the hold handshake alone. A reset during a granted hold checks that the asynchronous clear works and that release waits for the synchronised edge.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  // Ownership state of the hold handshake
  typedef enum logic {
    OWN_BUS      = 1'b0,
    HOLD_GRANTED = 1'b1
  } hold_state_e;

  // Number of active-low ready strobes watched by the block
  localparam int unsigned READY_CNT = 2;

endpackage

// File: rtl/bo_rst_sync.sv
module bo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bo_ready_arb.sv
module bo_ready_arb #(
  parameter int unsigned N_READY = 2
) (
  input  logic [N_READY-1:0] ready_n,
  input  logic               backoff_n,
  input  logic               floated,
  input  logic               cyc_busy,
  input  logic               cyc_last,
  output logic               xfer_done,
  output logic               boundary
);

  logic [N_READY-1:0] ready_hit;
  logic               any_ready;

  // One active-high hit per ready strobe
  for (genvar g = 0; g < N_READY; g++) begin : g_rdy
    assign ready_hit[g] = ~ready_n[g];
  end

  always_comb begin
    any_ready = |ready_hit;
    // Backoff overrides ready; a floated bus completes nothing
    xfer_done = cyc_busy && any_ready && backoff_n && !floated;
    // Hold may be taken with nothing in flight or as a cycle closes
    boundary  = !cyc_busy || (xfer_done && cyc_last);
  end

endmodule

// File: rtl/bo_hold_fsm.sv
module bo_hold_fsm
  import bus_own_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic boundary,
  output logic hold_ack
);

  hold_state_e state_q, state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_BUS:      if (hold_req && boundary) state_d = HOLD_GRANTED;
      HOLD_GRANTED: if (!hold_req)            state_d = OWN_BUS;
      default:                                state_d = OWN_BUS;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= OWN_BUS;
    else if (state_en) state_q <= state_d;
  end

  assign hold_ack = (state_q == HOLD_GRANTED);

endmodule

// File: rtl/bo_backoff_trk.sv
module bo_backoff_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic backoff_n,
  input  logic cyc_busy,
  output logic boff_float,
  output logic cyc_abort,
  output logic cyc_restart
);

  logic boff_q, boff_d;
  logic pend_q, pend_d, pend_en;
  logic rstrt_q, rstrt_d;
  logic release_now;

  always_comb begin
    release_now = backoff_n && boff_q;
    boff_d      = !backoff_n;
    pend_d      = pend_q;
    if (!backoff_n && cyc_busy) pend_d = 1'b1;
    else if (release_now)       pend_d = 1'b0;
    pend_en     = (pend_d != pend_q);
    rstrt_d     = release_now && pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boff_q  <= 1'b0;
      pend_q  <= 1'b0;
      rstrt_q <= 1'b0;
    end else begin
      boff_q  <= boff_d;
      rstrt_q <= rstrt_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign boff_float  = boff_q;
  // Abort is flagged once, in the clock backoff first meets the cycle
  assign cyc_abort   = !backoff_n && cyc_busy && !pend_q;
  assign cyc_restart = rstrt_q;

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic backoff_n,
  input  logic rdy_n,
  input  logic brdy_n,
  input  logic cyc_busy,
  input  logic cyc_last,
  output logic hold_ack,
  output logic bus_float,
  output logic xfer_done,
  output logic cyc_abort,
  output logic cyc_restart
);

  logic                 rst_sync_n;
  logic [READY_CNT-1:0] ready_vec_n;
  logic                 boundary;
  logic                 ack_int;
  logic                 boff_float;

  assign ready_vec_n = {brdy_n, rdy_n};

  bo_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bo_ready_arb #(.N_READY(READY_CNT)) u_arb (
    .ready_n   (ready_vec_n),
    .backoff_n (backoff_n),
    .floated   (bus_float),
    .cyc_busy  (cyc_busy),
    .cyc_last  (cyc_last),
    .xfer_done (xfer_done),
    .boundary  (boundary)
  );

  bo_hold_fsm u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hold_req (hold_req),
    .boundary (boundary),
    .hold_ack (ack_int)
  );

  bo_backoff_trk u_boff (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .backoff_n   (backoff_n),
    .cyc_busy    (cyc_busy),
    .boff_float  (boff_float),
    .cyc_abort   (cyc_abort),
    .cyc_restart (cyc_restart)
  );

  assign hold_ack  = ack_int;
  assign bus_float = ack_int | boff_float;

endmodule

// File: rtl/bus_own_chk.sv
module bus_own_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic backoff_n,
  input logic cyc_busy,
  input logic cyc_last,
  input logic hold_ack,
  input logic bus_float,
  input logic xfer_done,
  input logic cyc_restart
);

  // R2: acknowledge never appears without floated pins
  a_r2_ack_implies_float: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> bus_float);

  // R3: grant only after a boundary clock
  a_r3_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!cyc_busy || (xfer_done && cyc_last)));

  // R4: hold released next clock
  a_r4_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  // R5 / R9: acknowledge tracks only the hold request
  a_r5_ack_from_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> $past(hold_req));

  // R7: floated in the clock after backoff is sampled
  a_r7_float_under_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    !backoff_n |=> bus_float);

  // R6: backoff beats ready
  a_r6_backoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !backoff_n |-> !xfer_done);

  // R8: restart lasts one clock and follows a release
  a_r8_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_restart |=> !cyc_restart);

  a_r8_restart_after_boff: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_restart |-> $past(!backoff_n, 2));

endmodule

bind bus_own_ctrl bus_own_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .hold_req    (hold_req),
  .backoff_n   (backoff_n),
  .cyc_busy    (cyc_busy),
  .cyc_last    (cyc_last),
  .hold_ack    (hold_ack),
  .bus_float   (bus_float),
  .xfer_done   (xfer_done),
  .cyc_restart (cyc_restart)
);

// File: tb/sim_bus_own_ctrl.sv
module sim_bus_own_ctrl;

  logic clk = 1'b0;
  logic rst_n, hold_req, backoff_n, rdy_n, brdy_n, cyc_busy, cyc_last;
  logic hold_ack, bus_float, xfer_done, cyc_abort, cyc_restart;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  bus_own_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .backoff_n(backoff_n),
    .rdy_n(rdy_n), .brdy_n(brdy_n), .cyc_busy(cyc_busy), .cyc_last(cyc_last),
    .hold_ack(hold_ack), .bus_float(bus_float), .xfer_done(xfer_done),
    .cyc_abort(cyc_abort), .cyc_restart(cyc_restart)
  );

  // {hold, boff_n, rdy_n, brdy_n, busy, last | ack, float, done, abort, restart}
  // Expected outputs are those seen in the same clock as the inputs.
  localparam int NV = 33;
  localparam logic [10:0] VEC [NV] = '{
    11'b010000_00000, // 0  idle
    11'b010110_00100, // 1  rdy accepted
    11'b011010_00100, // 2  brdy accepted
    11'b111110_00000, // 3  hold mid-cycle
    11'b110111_00100, // 4  last transfer closes cycle
    11'b111100_11000, // 5  granted
    11'b111100_11000, // 6
    11'b011100_11000, // 7  hold dropped
    11'b011100_00000, // 8  released
    11'b111100_00000, // 9  hold on idle bus
    11'b111100_11000, // 10 granted together
    11'b011100_11000, // 11
    11'b011100_00000, // 12
    11'b000110_00010, // 13 backoff + rdy, busy
    11'b001110_01000, // 14 floated, no ack
    11'b001110_01000, // 15 still floated
    11'b011110_01000, // 16 backoff released
    11'b011110_00001, // 17 restart pulse
    11'b010111_00100, // 18 cycle completes
    11'b001100_00000, // 19 backoff on idle bus
    11'b011100_01000, // 20
    11'b011100_00000, // 21 no restart
    11'b111100_00000, // 22 hold
    11'b101100_11000, // 23 backoff over hold
    11'b001100_11000, // 24 hold dropped
    11'b001100_01000, // 25 ack gone, still floated
    11'b011100_01000, // 26 backoff released
    11'b011100_00000, // 27
    11'b001100_00000, // 28 backoff first
    11'b101100_01000, // 29 hold during backoff
    11'b111100_11000, // 30 granted
    11'b011100_11000, // 31
    11'b011100_00000  // 32
  };

  function automatic string tag_of(int i);
    if (i == 0)       return "R1";
    else if (i <= 2)  return "R10";
    else if (i <= 6)  return "R3";
    else if (i <= 8)  return "R4";
    else if (i <= 12) return "R2";
    else if (i == 13) return "R6";
    else if (i == 14) return "R5";
    else if (i == 15) return "R7";
    else if (i <= 21) return "R8";
    else              return "R9";
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: outputs ack/float/done/abort/restart actual %b expected %b",
               req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {hold_ack, bus_float, xfer_done, cyc_abort, cyc_restart};
  endfunction

  task automatic drive(logic [5:0] v);
    {hold_req, backoff_n, rdy_n, brdy_n, cyc_busy, cyc_last} = v;
  endtask

  initial begin
    #(20 * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(6'b010000);
    repeat (3) @(negedge clk);
    // R1: reset state while held
    #2 check("R1", outs(), 5'b00000);
    // R1: hold request during reset is ignored
    drive(6'b110000);
    @(negedge clk); #2 check("R1", outs(), 5'b00000);
    drive(6'b010000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2 check("R1", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:5]);
      #2 check(tag_of(i), outs(), VEC[i][4:0]);
    end

    // R1: asynchronous clear while a hold is granted
    @(negedge clk); drive(6'b110000);
    @(negedge clk); @(negedge clk);
    #2 check("R2", outs(), 5'b11000);
    rst_n = 1'b0;
    #2 check("R1", outs(), 5'b00000);
    @(negedge clk); rst_n = 1'b1;
    // R1: first clocks after release stay in reset despite hold
    @(negedge clk); #2 check("R1", outs(), 5'b00000);
    repeat (3) @(negedge clk);
    #2 check("R2", outs(), 5'b11000);
    drive(6'b010000);
    @(negedge clk); @(negedge clk);
    #2 check("R4", outs(), 5'b00000);

    // R10: both ready strobes low together accepted once
    drive(6'b010010);
    #2 check("R10", outs(), 5'b00100);
    // R6: backoff with brdy on a busy bus
    @(negedge clk); drive(6'b001010);
    #2 check("R6", outs(), 5'b00010);
    @(negedge clk); drive(6'b011110);
    #2 check("R7", outs(), 5'b01000);
    @(negedge clk); drive(6'b011100);
    #2 check("R8", outs(), 5'b00001);
    @(negedge clk);
    #2 check("R8", outs(), 5'b00000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule